// File: doc/BRIEF.md
# Multiblock Auto-Stop Abort Sequencer

Some SD host controllers never signal transfer-complete at the end of a multiblock transfer whose length was fixed in advance by a set-block-count command. This block sits beside such a host and fixes the problem in hardware. It watches each command that software issues. When a set-block-count command has gone out, the next data-end event makes the block issue its own stop command. That stop command is marked as an abort and expects no response. The block then hides the single response-complete interrupt that its own stop causes, and it clears that interrupt in the raw status register through a clear strobe.

The block also keeps a hold-quirk flag for the host. The flag is raised when the transfer mode is written for an SDIO extended read of more than one block, and it drops on any data-end. Separately from the workaround, every stop command that software issues has its command type forced to abort. The card bus is not part of this block.

Top module: `mb_autostop`

## Requirements
- R1: Out of reset the tracker is idle. `stop_vld_o` is 0, `stop_word_o` is 0 and `hold_quirk_o` is 0. `irq_flt_o` equals `irq_raw_i` and `irq_clr_o` is 0.
- R2: With `quirk_en_i` high, a command with opcode 23 moves the tracker to multiblock. A `data_end_i` in that state gives `stop_vld_o` high in the following cycle, and the tracker moves to waiting.
- R3: A command with opcode 23 issued while `quirk_en_i` is low does not arm the tracker, so no later data-end produces a stop.
- R4: A `data_end_i` while the tracker is idle or waiting produces no stop command.
- R5: In the waiting state, a raw status word with the response-complete bit set (bit 0) is shown with that bit cleared on `irq_flt_o`. In the same cycle `irq_clr_o` carries only bit 0. The tracker then returns to idle, so the next response-complete passes through unchanged.
- R6: Outside the case in R5, `irq_flt_o` equals `irq_raw_i` and `irq_clr_o` is zero.
- R7: `cmd_type_o` is 2'b11 (abort) whenever `cmd_opc_i` is 12. For any other opcode it equals `cmd_type_i`.
- R8: With `quirk_en_i` high, a transfer-mode write for opcode 53 that is a read of more than one block sets `hold_quirk_o` in the next cycle. A single-block or write transfer leaves it unchanged.
- R9: With `quirk_en_i` high, `data_end_i` clears `hold_quirk_o` in the next cycle in any tracker state. If a transfer-mode write that sets the flag comes in the same cycle, the set wins.
- R10: `stop_vld_o` is a one-cycle pulse. While it is high, `stop_word_o` holds opcode 12 in bits 29:24 and type 2'b11 in bits 23:22, with every other bit zero (0x0CC00000). While it is low, `stop_word_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| quirk_en_i | input | 1 | Enables the auto-stop workaround and the hold-quirk flag |
| cmd_vld_i | input | 1 | A software command is being issued this cycle |
| cmd_opc_i | input | 6 | Opcode of the software command |
| cmd_type_i | input | 2 | Command type requested by software |
| cmd_type_o | output | 2 | Command type after stop tagging |
| mode_wr_i | input | 1 | Transfer-mode write strobe |
| mode_opc_i | input | 6 | Opcode of the command the transfer mode belongs to |
| mode_blocks_i | input | 16 | Block count of that transfer |
| mode_read_i | input | 1 | That transfer is a read |
| data_end_i | input | 1 | Data-end event pulse |
| hold_quirk_o | output | 1 | Hold-quirk flag for the host |
| stop_vld_o | output | 1 | Inserted stop command request |
| stop_word_o | output | 32 | Command word of the inserted stop |
| irq_raw_i | input | 32 | Raw interrupt status |
| irq_flt_o | output | 32 | Filtered interrupt status |
| irq_clr_o | output | 32 | Write-one-to-clear strobe toward the raw status |

## Verification
The bench first checks the inserted stop word and its timing exactly one cycle after data-end. A design that issued the stop in the wrong cycle, or packed the fields in the wrong place, fails at once. It then sends data-end while idle and again while waiting. A design that issued a second stop there would double-abort the card. It also sends a response-complete in the waiting state together with other pending bits. A design that masked too much would hide real events, one that cleared too much would lose them, and one that stayed in waiting would swallow the next genuine response. Random stimulus covers the set-block-count command arriving in the same cycle as other events, the disabled workaround, and the tie between setting and clearing the hold flag.

// File: rtl/mb_autostop.sv
module mb_autostop #(
  parameter int OPC_W      = 6,
  parameter int BLK_W      = 16,
  parameter int STS_W      = 32,
  parameter int WORD_W     = 32,
  parameter int RESP_BIT   = 0,
  parameter int OPC_STOP   = 12,
  parameter int OPC_SETCNT = 23,
  parameter int OPC_SDIOX  = 53,
  parameter int OPC_LSB    = 24,
  parameter int TYPE_LSB   = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              quirk_en_i,
  input  logic              cmd_vld_i,
  input  logic [OPC_W-1:0]  cmd_opc_i,
  input  logic [1:0]        cmd_type_i,
  output logic [1:0]        cmd_type_o,
  input  logic              mode_wr_i,
  input  logic [OPC_W-1:0]  mode_opc_i,
  input  logic [BLK_W-1:0]  mode_blocks_i,
  input  logic              mode_read_i,
  input  logic              data_end_i,
  output logic              hold_quirk_o,
  output logic              stop_vld_o,
  output logic [WORD_W-1:0] stop_word_o,
  input  logic [STS_W-1:0]  irq_raw_i,
  output logic [STS_W-1:0]  irq_flt_o,
  output logic [STS_W-1:0]  irq_clr_o
);

  localparam logic [1:0]        TYPE_ABORT = 2'b11;
  localparam logic [WORD_W-1:0] STOP_WORD  =
    (WORD_W'(OPC_STOP) << OPC_LSB) | (WORD_W'(TYPE_ABORT) << TYPE_LSB);
  localparam logic [STS_W-1:0]  RESP_MASK  = STS_W'(1) << RESP_BIT;

  typedef enum logic [1:0] {S_IDLE, S_MB, S_WAIT} st_e;

  st_e  state_q, state_d;
  logic stop_q, quirk_q;

  wire arm_w    = quirk_en_i && cmd_vld_i && (cmd_opc_i == OPC_W'(OPC_SETCNT));
  wire fire_w   = quirk_en_i && data_end_i && (state_q == S_MB);
  wire swallow  = (state_q == S_WAIT) && irq_raw_i[RESP_BIT];
  wire q_set_w  = quirk_en_i && mode_wr_i && mode_read_i
                  && (mode_opc_i == OPC_W'(OPC_SDIOX))
                  && (mode_blocks_i > BLK_W'(1));
  wire q_clr_w  = quirk_en_i && data_end_i;

  always_comb begin
    state_d = state_q;
    if (fire_w)       state_d = S_WAIT;
    else if (arm_w)   state_d = S_MB;
    else if (swallow) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      stop_q  <= 1'b0;
      quirk_q <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= fire_w;
      if (q_set_w)      quirk_q <= 1'b1;
      else if (q_clr_w) quirk_q <= 1'b0;
    end
  end

  assign cmd_type_o   = (cmd_opc_i == OPC_W'(OPC_STOP)) ? TYPE_ABORT : cmd_type_i;
  assign stop_vld_o   = stop_q;
  assign stop_word_o  = stop_q ? STOP_WORD : '0;
  assign hold_quirk_o = quirk_q;
  assign irq_flt_o    = swallow ? (irq_raw_i & ~RESP_MASK) : irq_raw_i;
  assign irq_clr_o    = swallow ? RESP_MASK : '0;

  AST_STOP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_vld_o |=> !stop_vld_o); // R10
  AST_STOP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_vld_o |-> $past(data_end_i && quirk_en_i)); // R2
  AST_WORD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_vld_o |-> (stop_word_o == '0)); // R10
  AST_CLR_RESP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_o & ~RESP_MASK) == '0); // R5
  AST_FLT_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flt_o & ~irq_raw_i) == '0); // R6
  AST_QUIRK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quirk_en_i && data_end_i && !mode_wr_i) |=> !hold_quirk_o); // R9

endmodule

// File: tb/mb_autostop_tb.sv
module mb_autostop_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qe = 1'b0, cv = 1'b0, mw = 1'b0, mrd = 1'b0, de = 1'b0;
  logic [5:0]  copc = '0, mopc = '0;
  logic [1:0]  ctype = '0, type_o;
  logic [15:0] mblk = '0;
  logic [31:0] raw = '0, word, flt, clr;
  logic        hq, sv;

  int checks = 0, errors = 0, cyc = 0;
  int m_state = 0;
  logic m_stop = 1'b0, m_quirk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mb_autostop dut_i (
    .clk_i(clk), .rst_ni(rst_n), .quirk_en_i(qe),
    .cmd_vld_i(cv), .cmd_opc_i(copc), .cmd_type_i(ctype), .cmd_type_o(type_o),
    .mode_wr_i(mw), .mode_opc_i(mopc), .mode_blocks_i(mblk), .mode_read_i(mrd),
    .data_end_i(de), .hold_quirk_o(hq), .stop_vld_o(sv), .stop_word_o(word),
    .irq_raw_i(raw), .irq_flt_o(flt), .irq_clr_o(clr)
  );

  function automatic logic [31:0] f_flt(int st, logic [31:0] r);
    return (st == 2 && r[0]) ? (r & 32'hFFFF_FFFE) : r;
  endfunction
  function automatic logic [31:0] f_clr(int st, logic [31:0] r);
    return (st == 2 && r[0]) ? 32'h1 : 32'h0;
  endfunction
  function automatic logic [1:0] f_type(logic [5:0] o, logic [1:0] t);
    return (o == 6'd12) ? 2'b11 : t;
  endfunction
  function automatic logic [31:0] f_word(logic s);
    return s ? 32'h0CC0_0000 : 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    cv = 0; mw = 0; de = 0; mrd = 0; copc = 6'd0; mopc = 6'd0;
    ctype = 2'b00; mblk = 16'd0; raw = 32'h0;
  endtask

  task automatic tick();
    logic stop_n, q_set;
    int st_n;
    chk("R10 stop valid", {31'b0, sv}, {31'b0, m_stop});
    chk("R10 stop word", word, f_word(m_stop));
    chk("R6 filtered", flt, f_flt(m_state, raw));
    chk("R5 clear", clr, f_clr(m_state, raw));
    chk("R8 quirk", {31'b0, hq}, {31'b0, m_quirk});
    chk("R7 type", {30'b0, type_o}, {30'b0, f_type(copc, ctype)});
    stop_n = qe && de && (m_state == 1);
    st_n = m_state;
    if (stop_n) st_n = 2;
    else if (qe && cv && copc == 6'd23) st_n = 1;
    else if (m_state == 2 && raw[0]) st_n = 0;
    q_set = qe && mw && mrd && mopc == 6'd53 && mblk > 16'd1;
    @(posedge clk);
    m_state = st_n;
    m_stop = stop_n;
    if (q_set) m_quirk = 1'b1;
    else if (qe && de) m_quirk = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL R1 watchdog actual %0d expected below 100000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    raw = 32'h5; #1;
    chk("R1 stop", {31'b0, sv}, 32'h0);
    chk("R1 word", word, 32'h0);
    chk("R1 quirk", {31'b0, hq}, 32'h0);
    chk("R1 flt", flt, 32'h5);
    chk("R1 clr", clr, 32'h0);
    tick();
    // R2 arm and fire
    @(negedge clk); idle_in(); qe = 1; cv = 1; copc = 6'd23; #1; tick();
    @(negedge clk); idle_in(); de = 1; #1; tick();
    @(negedge clk); idle_in(); #1;
    chk("R2 stop pulse", {31'b0, sv}, 32'h1);
    chk("R10 word", word, 32'h0CC0_0000);
    tick();
    // R4 data-end in waiting: no second stop
    @(negedge clk); idle_in(); de = 1; #1; tick();
    @(negedge clk); idle_in(); #1;
    chk("R4 no stop in waiting", {31'b0, sv}, 32'h0);
    // R5 swallow response
    raw = 32'h0000_0103; #1;
    chk("R5 flt", flt, 32'h0000_0102);
    chk("R5 clr", clr, 32'h1);
    tick();
    @(negedge clk); idle_in(); raw = 32'h1; #1;
    chk("R5 back to idle", flt, 32'h1);
    chk("R6 no clr", clr, 32'h0);
    tick();
    // R4 data-end in idle
    @(negedge clk); idle_in(); de = 1; #1; tick();
    @(negedge clk); idle_in(); #1;
    chk("R4 no stop in idle", {31'b0, sv}, 32'h0);
    tick();
    // R3 disabled workaround
    @(negedge clk); idle_in(); qe = 0; cv = 1; copc = 6'd23; #1; tick();
    @(negedge clk); idle_in(); de = 1; #1; tick();
    @(negedge clk); idle_in(); #1;
    chk("R3 no stop when disabled", {31'b0, sv}, 32'h0);
    tick();
    // R7 stop tagging
    @(negedge clk); idle_in(); copc = 6'd12; ctype = 2'b01; #1;
    chk("R7 stop abort", {30'b0, type_o}, 32'h3);
    copc = 6'd17; #1;
    chk("R7 other passes", {30'b0, type_o}, 32'h1);
    tick();
    // R8 hold flag
    @(negedge clk); idle_in(); qe = 1; mw = 1; mopc = 6'd53; mrd = 1; mblk = 16'd1; #1; tick();
    @(negedge clk); idle_in(); qe = 1; mw = 1; mopc = 6'd53; mrd = 0; mblk = 16'd4; #1;
    chk("R8 single block keeps low", {31'b0, hq}, 32'h0);
    tick();
    @(negedge clk); idle_in(); qe = 1; mw = 1; mopc = 6'd53; mrd = 1; mblk = 16'd4; #1;
    chk("R8 write keeps low", {31'b0, hq}, 32'h0);
    tick();
    @(negedge clk); idle_in(); qe = 1; #1;
    chk("R8 multiblock read sets", {31'b0, hq}, 32'h1);
    // R9 data-end clears
    de = 1; #1; tick();
    @(negedge clk); idle_in(); qe = 1; #1;
    chk("R9 data-end clears", {31'b0, hq}, 32'h0);
    tick();
    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      idle_in();
      qe   = ($urandom % 8) != 0;
      cv   = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: copc = 6'd23;
        1: copc = 6'd12;
        2: copc = 6'd53;
        default: copc = 6'($urandom);
      endcase
      ctype = 2'($urandom);
      mw   = ($urandom % 5) == 0;
      mopc = (($urandom % 2) == 0) ? 6'd53 : 6'($urandom);
      mblk = 16'($urandom % 4);
      mrd  = $urandom % 2;
      de   = ($urandom % 4) == 0;
      raw  = $urandom & 32'h0000_0FFE;
      raw[0] = ($urandom % 3) == 0;
      #1;
      tick();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule